// File: doc/BRIEF.md
# Marker-bit asynchronous serial transmitter

This block serialises one byte at a time onto an asynchronous line. Each frame is ten bit times long: a low start bit, the data bits with the least significant bit first, and a high stop bit. Bit timing comes from a free-running divide-by-N counter that advances on a 16x baud tick enable supplied from outside. The frame begins at the first counter wrap after the write, not at the write itself, so every bit edge lines up with a counter wrap.

A one-cycle write strobe loads the byte into a 9-bit shift register and places a 1 marker above it. Each data shift moves the register right and fills it with 0 from the left. The block never counts bits. It sees that the frame is over when the marker sits just above the output position with only zeros above it. It then makes one last shift, which puts the marker on the line as the stop bit, and raises a done flag. The done flag stays high until the clear input is pulsed.

Top module: `marker_uart_tx`

## Requirements
- R1: While rst_ni is low and after reset, txd_o is 1 and done_o is 0.
- R2: The bit-time counter advances only in cycles where tick_i is 1 and wraps from OVERSAMPLE-1 to 0. A write waiting for a wrap does not start while tick_i stays 0.
- R3: A write (wr_i high for one cycle while idle) captures wr_data_i and a 1 marker above it. txd_o stays 1 until the first counter wrap after the write edge.
- R4: The bit time that starts at the first wrap after the write drives txd_o to 0 (start bit).
- R5: Data bit k (k = 0 for the LSB) is on txd_o during the bit time that starts at wrap k+2 after the write. txd_o changes only at counter wraps.
- R6: The end of the frame is found from the marker pattern (marker just above the output bit, zeros above it). The final shift happens at wrap 10 after the write and sets done_o to 1. From that point txd_o is 1 (stop bit).
- R7: Once set, done_o stays 1 until clr_done_i is high at a clock edge with no new completion, which clears it. Writing a new frame does not clear it.
- R8: A write while a frame is waiting or in progress is ignored: the current frame's bits are unchanged and no second frame follows.
- R9: When no frame is active, txd_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x baud tick enable for the bit-time counter |
| wr_i | input | 1 | One-cycle write strobe |
| wr_data_i | input | DATA_W | Byte to send |
| clr_done_i | input | 1 | Clears the done flag |
| txd_o | output | 1 | Serial output line, idle high |
| done_o | output | 1 | Frame-complete flag |

## Verification
The bench builds the block with OVERSAMPLE = 4 and DATA_W = 8. The short bit time keeps each frame near forty cycles, so many byte patterns, writes during a frame, and changes of tick rate fit in a short run. Because the counter is only two bits wide, writes land at every counter phase. This checks that the start bit follows the counter wrap and not the write. A stopped tick and a tick at every other cycle check that the bit timing follows the enable alone.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_START = 2'd2,
    TX_DATA  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/mtx_baud_div.sv
module mtx_baud_div #(
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign roll_o = tick_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (roll_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mtx_shreg.sv
module mtx_shreg #(
  parameter int DATA_W = 8,
  localparam int SH_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic [SH_W-1:0]   sh_o,
  output logic              last_o
);
  logic [SH_W-1:0] sh_q;

  assign sh_o   = sh_q;
  // marker directly above output bit, zeros above it
  assign last_o = (sh_q[SH_W-1:1] == DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= {1'b1, data_i};
    else if (shift_i) sh_q <= {1'b0, sh_q[SH_W-1:1]};
  end
endmodule

// File: rtl/mtx_ctrl.sv
module mtx_ctrl
  import mtx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      roll_i,
  input  logic      wr_i,
  input  logic      last_i,
  input  logic      out_bit_i,
  input  logic      clr_i,
  output logic      load_o,
  output logic      shift_o,
  output logic      txd_o,
  output logic      done_o,
  output tx_state_e state_o
);
  tx_state_e state_q, state_d;
  logic      done_q, set_done;

  assign load_o   = wr_i && (state_q == TX_IDLE);
  assign shift_o  = roll_i && (state_q == TX_DATA);
  assign set_done = shift_o && last_i;
  assign state_o  = state_q;
  assign done_o   = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TX_IDLE:  if (wr_i)   state_d = TX_WAIT;
      TX_WAIT:  if (roll_i) state_d = TX_START;
      TX_START: if (roll_i) state_d = TX_DATA;
      TX_DATA:  if (set_done) state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = out_bit_i;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_done)   done_q <= 1'b1;
      else if (clr_i) done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/marker_uart_tx.sv
module marker_uart_tx
  import mtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1,
  localparam int SH_W  = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_done_i,
  output logic              txd_o,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             roll_w, load_w, shift_w, last_w;
  logic [SH_W-1:0]  sh_w;
  tx_state_e        state_w;

  mtx_baud_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_w),
    .roll_o (roll_w)
  );

  mtx_shreg #(.DATA_W(DATA_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_w),
    .data_i  (wr_data_i),
    .shift_i (shift_w),
    .sh_o    (sh_w),
    .last_o  (last_w)
  );

  mtx_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .roll_i    (roll_w),
    .wr_i      (wr_i),
    .last_i    (last_w),
    .out_bit_i (sh_w[0]),
    .clr_i     (clr_done_i),
    .load_o    (load_w),
    .shift_o   (shift_w),
    .txd_o     (txd_o),
    .done_o    (done_o),
    .state_o   (state_w)
  );
endmodule

// File: rtl/marker_uart_tx_chk.sv
module marker_uart_tx_chk
  import mtx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1,
  localparam int SH_W  = DATA_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              clr_done_i,
  input logic              txd_i,
  input logic              done_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              roll_i,
  input logic [SH_W-1:0]   sh_i,
  input tx_state_e         state_i
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == LAST) |=> (cnt_i == '0));

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && state_i == TX_IDLE) |=>
      (sh_i == {1'b1, $past(wr_data_i)}) && (state_i == TX_WAIT) && txd_i);

  // R5
  edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_i) |-> $past(roll_i));

  // R6
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll_i && state_i == TX_DATA) |=> !sh_i[SH_W-1]);

  // R6
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> ($past(state_i == TX_DATA && roll_i) && state_i == TX_IDLE && txd_i));

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clr_done_i) |=> done_i);

  // R8
  busy_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && state_i != TX_IDLE && !roll_i) |=> $stable(sh_i));

  // R9
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == TX_IDLE || state_i == TX_WAIT) |-> txd_i);
endmodule

bind marker_uart_tx marker_uart_tx_chk #(
  .DATA_W     (DATA_W),
  .OVERSAMPLE (OVERSAMPLE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_i       (wr_i),
  .wr_data_i  (wr_data_i),
  .clr_done_i (clr_done_i),
  .txd_i      (txd_o),
  .done_i     (done_o),
  .cnt_i      (cnt_w),
  .roll_i     (roll_w),
  .sh_i       (sh_w),
  .state_i    (state_w)
);

// File: tb/sim_marker_uart_tx.sv
module sim_marker_uart_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int DW         = 8;
  localparam int BW         = $clog2(DIV);
  localparam int NVEC       = 6;
  // {data[19:12], intruder[11:4], intrude_en[3], tick_mode[1:0]}
  // tick_mode: 0 steady, 1 every other cycle, 2 paused after write
  localparam logic [19:0] VEC [NVEC] = '{
    {8'hA5, 8'h00, 1'b0, 1'b0, 2'd0},
    {8'h00, 8'hFF, 1'b1, 1'b0, 2'd0},
    {8'hFF, 8'h00, 1'b0, 1'b0, 2'd1},
    {8'h01, 8'h7E, 1'b1, 1'b0, 2'd0},
    {8'h80, 8'h00, 1'b0, 1'b0, 2'd2},
    {8'h3C, 8'hC3, 1'b1, 1'b0, 2'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          clr = 1'b0;
  logic          txd, done;
  logic          gate = 1'b0, pause = 1'b0;
  logic [BW-1:0] bcnt;
  int            n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  marker_uart_tx #(.DATA_W(DW), .OVERSAMPLE(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .clr_done_i(clr), .txd_o(txd), .done_o(done)
  );

  always_ff @(posedge clk)
    tick <= pause ? 1'b0 : (gate ? ~tick : 1'b1);

  // bench-side bit-time counter per R2
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else if (tick) bcnt <= (bcnt == BW'(DIV-1)) ? '0 : bcnt + 1'b1;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the negedge after the next wrap
  task automatic next_roll();
    while (!(tick && bcnt == BW'(DIV-1))) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [DW-1:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic run_frame(input logic [19:0] v);
    logic [DW-1:0] d;
    d = v[19:12];
    gate = (v[1:0] == 2'd1);
    @(negedge clk);
    if (v[1:0] == 2'd2) while (!(bcnt == '0 && tick)) @(negedge clk);
    pulse_wr(d);
    chk("R3", txd, 1'b1);
    if (v[1:0] == 2'd2) begin
      pause = 1'b1;
      repeat (3*DIV) @(negedge clk);
      chk("R2", txd, 1'b1);
      pause = 1'b0;
      @(negedge clk);
    end
    next_roll();
    chk("R4", txd, 1'b0);
    for (int i = 0; i < DW; i++) begin
      next_roll();
      chk("R5", txd, d[i]);
      if (i == 3 && v[3]) pulse_wr(v[11:4]);
    end
    chk("R6", done, 1'b0);
    next_roll();
    chk("R6", done, 1'b1);
    chk("R6", txd, 1'b1);
    next_roll();
    chk(v[3] ? "R8" : "R9", txd, 1'b1);
    next_roll();
    chk(v[3] ? "R8" : "R9", txd, 1'b1);
    chk("R7", done, 1'b1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R7", done, 1'b0);
    gate = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", txd, 1'b1);
    chk("R1", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", txd, 1'b1);
    chk("R1", done, 1'b0);

    for (int k = 0; k < NVEC; k++) run_frame(VEC[k]);

    // done survives a new write and only clr drops it (R7)
    @(negedge clk);
    pulse_wr(8'h5A);
    next_roll();
    chk("R4", txd, 1'b0);
    repeat (DW + 1) next_roll();
    chk("R6", done, 1'b1);
    pulse_wr(8'h96);
    chk("R7", done, 1'b1);
    next_roll();
    chk("R4", txd, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7", done, 1'b1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R7", done, 1'b0);
    repeat (DW + 1) next_roll();
    chk("R6", done, 1'b1);

    // reset mid-frame returns line high
    pulse_wr(8'h00);
    next_roll();
    chk("R4", txd, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1", txd, 1'b1);
    chk("R1", done, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule